// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

The block turns one 21-bit display word per pixel period into three serial data lanes and a framing clock lane. Each pixel period is cut into seven bit slots. Every data lane carries seven bits of the word, one per slot. The clock lane repeats a fixed slot pattern so that a receiver can find the word boundary. The word is made of 18 colour bits (six each of red, green and blue) and three timing bits (line sync, frame sync and data enable).

All logic runs on one fast system clock. A slot-rate enable pulse (seven pulses per pixel period) comes from outside the block. The pixel clock is brought in as an ordinary input, synchronised, and edge-detected. A select input decides whether the rising or the falling pixel-clock edge samples the word, and falling is the default when the select is held low.

An active-low power-down input resets the block and disables every lane. A missing-clock detector mutes all four lanes to logic low while the pixel clock is absent. Because the block leaves power-down in the muted state, the clock may arrive at any time after power-down is released. Lanes are modelled as single-ended bits with a shared output enable.

Top module: `pixlink_serializer`

## Requirements
- R1: The word is assembled as red[5:0] in bits 5..0, green[5:0] in bits 11..6, blue[5:0] in bits 17..12, line sync in bit 18, frame sync in bit 19 and data enable in bit 20. Word bit 7*k+s is sent on data lane k (k = 0..2) in slot s.
- R2: The slot counter steps by one on each cycle with `bit_en` high, wraps from 6 to 0, and holds otherwise. A frame is sent in slot order 0 first through 6 last, and a new word is loaded into the frame at each wrap to slot 0.
- R3: While active, the clock lane carries 1,1,0,0,0,1,1 in slots 0 through 6.
- R4: With `edge_rise` high the word is captured on the rising pixel-clock edge. With it low it is captured on the falling edge. Input changes away from the selected edge are not sent.
- R5: While `pd_n` is low, `lane_oe_o` is 0 and every lane is 0, and this holds immediately. After release, `lane_oe_o` is 1 from the first clock on.
- R6: If no selected pixel-clock edge is seen within `LOSS_SLOTS` slot pulses, all four lanes are sent as 0 while `lane_oe_o` stays 1.
- R7: The block leaves power-down muted. The mute lifts on the `RECOVER_EDGES`-th consecutive selected edge (default 4), and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is registered on its rising edge |
| pd_n | input | 1 | Active-low power-down; asynchronous reset of the block |
| bit_en | input | 1 | Slot-rate enable, seven pulses per pixel period |
| pix_clk | input | 1 | Pixel clock, sampled as data |
| edge_rise | input | 1 | 1 selects rising-edge capture, 0 selects falling-edge capture |
| red | input | 6 | Red colour bits |
| grn | input | 6 | Green colour bits |
| blu | input | 6 | Blue colour bits |
| hsync | input | 1 | Line sync |
| vsync | input | 1 | Frame sync |
| de | input | 1 | Data enable |
| data_lane_o | output | 3 | Serial data lanes |
| clk_lane_o | output | 1 | Framing clock lane |
| lane_oe_o | output | 1 | Output enable for all four lanes |

## Verification
The hardest conditions to reach from the ports are the exact edges of the missing-clock state. These are the slot in which the mute begins after the pixel clock stops, and the point between the third and fourth returning edge at which it lifts. The bench produces the pixel clock from its own phase counter and counts the edges it makes. It stops the clock just after a falling edge and watches windows of slots on either side of each boundary. Edge selection is probed by changing the word at mid-period, so the two edges see different values.

// File: rtl/pxl_pkg.sv
`timescale 1ns/1ps
package pxl_pkg;
    localparam int SLOTS      = 7;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int DATA_LANES = 3;
    localparam int COLOR_W    = 6;
    localparam int WORD_W     = 3 * COLOR_W + 3;
    // bit s is the clock-lane value in slot s
    localparam logic [SLOTS-1:0] CLK_PAT = 7'b1100011;
endpackage

// File: rtl/pxl_edge_pick.sv
`timescale 1ns/1ps
module pxl_edge_pick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pd_n,
    input  logic pix_clk,
    input  logic rise_sel,
    output logic edge_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pix_clk};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) st_q <= '0;
        else       st_q <= st_d;
    end

    // pulse for one clock on the selected transition of the synchronised level
    assign edge_o = rise_sel ? ( st_q.sync[SYNC_STAGES-1] & ~st_q.prev)
                             : (~st_q.sync[SYNC_STAGES-1] &  st_q.prev);
endmodule

// File: rtl/pxl_clk_watch.sv
`timescale 1ns/1ps
module pxl_clk_watch #(
    parameter int LOSS_SLOTS    = 16,
    parameter int RECOVER_EDGES = 4
) (
    input  logic clk,
    input  logic pd_n,
    input  logic bit_en,
    input  logic edge_i,
    output logic lost_o
);
    localparam int GAP_W  = $clog2(LOSS_SLOTS + 1);
    localparam int GOOD_W = $clog2(RECOVER_EDGES + 1);

    typedef struct packed {
        logic [GAP_W-1:0]  gap;
        logic [GOOD_W-1:0] good;
        logic              lost;
    } watch_t;

    watch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_i) begin
            st_d.gap = '0;
            if (st_q.lost) begin
                if (st_q.good == GOOD_W'(RECOVER_EDGES - 1)) begin
                    st_d.lost = 1'b0;
                    st_d.good = '0;
                end else begin
                    st_d.good = st_q.good + 1'b1;
                end
            end
        end else if (bit_en) begin
            if (st_q.gap >= GAP_W'(LOSS_SLOTS - 1)) begin
                st_d.lost = 1'b1;
                st_d.good = '0;
            end else begin
                st_d.gap = st_q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            st_q      <= '0;
            st_q.lost <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lost_o = st_q.lost;
endmodule

// File: rtl/pxl_lane_serializer.sv
`timescale 1ns/1ps
module pxl_lane_serializer
    import pxl_pkg::*;
(
    input  logic                  clk,
    input  logic                  pd_n,
    input  logic                  bit_en,
    input  logic                  cap_en,
    input  logic [WORD_W-1:0]     word_i,
    input  logic                  mute_i,
    output logic [DATA_LANES-1:0] data_o,
    output logic                  clk_lane_o,
    output logic                  oe_o,
    output logic [SLOT_W-1:0]     slot_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [WORD_W-1:0]     hold;
        logic [WORD_W-1:0]     frm;
        logic [SLOT_W-1:0]     slot;
        logic [DATA_LANES-1:0] dat;
        logic                  ck;
        logic                  oe;
    } ser_t;

    ser_t              st_d, st_q;
    logic [SLOT_W-1:0] nslot;
    logic [WORD_W-1:0] src;

    always_comb begin
        st_d    = st_q;
        st_d.oe = 1'b1;
        nslot   = (st_q.slot == LAST_SLOT) ? '0 : st_q.slot + 1'b1;
        src     = (st_q.slot == LAST_SLOT) ? st_q.hold : st_q.frm;
        if (cap_en) st_d.hold = word_i;
        if (bit_en) begin
            st_d.slot = nslot;
            if (st_q.slot == LAST_SLOT) st_d.frm = st_q.hold;
            for (int s = 0; s < SLOTS; s++) begin
                if (nslot == SLOT_W'(s)) begin
                    for (int k = 0; k < DATA_LANES; k++)
                        st_d.dat[k] = ~mute_i & src[k*SLOTS + s];
                    st_d.ck = ~mute_i & CLK_PAT[s];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            st_q      <= '0;
            st_q.slot <= LAST_SLOT;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o     = st_q.dat;
    assign clk_lane_o = st_q.ck;
    assign oe_o       = st_q.oe;
    assign slot_o     = st_q.slot;
endmodule

// File: rtl/pixlink_serializer.sv
`timescale 1ns/1ps
module pixlink_serializer
    import pxl_pkg::*;
#(
    parameter int LOSS_SLOTS    = 16,
    parameter int RECOVER_EDGES = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic               clk,
    input  logic               pd_n,
    input  logic               bit_en,
    input  logic               pix_clk,
    input  logic               edge_rise,
    input  logic [COLOR_W-1:0] red,
    input  logic [COLOR_W-1:0] grn,
    input  logic [COLOR_W-1:0] blu,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               de,
    output logic [2:0]         data_lane_o,
    output logic               clk_lane_o,
    output logic               lane_oe_o
);
    logic              edge_w;
    logic              lost_w;
    logic [SLOT_W-1:0] slot_w;
    logic [WORD_W-1:0] word_w;

    assign word_w = {de, vsync, hsync, blu, grn, red};

    pxl_edge_pick #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk      (clk),
        .pd_n     (pd_n),
        .pix_clk  (pix_clk),
        .rise_sel (edge_rise),
        .edge_o   (edge_w)
    );

    pxl_clk_watch #(.LOSS_SLOTS(LOSS_SLOTS), .RECOVER_EDGES(RECOVER_EDGES)) i_watch (
        .clk    (clk),
        .pd_n   (pd_n),
        .bit_en (bit_en),
        .edge_i (edge_w),
        .lost_o (lost_w)
    );

    pxl_lane_serializer i_ser (
        .clk        (clk),
        .pd_n       (pd_n),
        .bit_en     (bit_en),
        .cap_en     (edge_w),
        .word_i     (word_w),
        .mute_i     (lost_w),
        .data_o     (data_lane_o),
        .clk_lane_o (clk_lane_o),
        .oe_o       (lane_oe_o),
        .slot_o     (slot_w)
    );
endmodule

// File: rtl/pxl_serializer_chk.sv
`timescale 1ns/1ps
module pxl_serializer_chk
    import pxl_pkg::*;
(
    input logic              clk,
    input logic              pd_n,
    input logic              bit_en,
    input logic [2:0]        data_lane_o,
    input logic              clk_lane_o,
    input logic              lane_oe_o,
    input logic [SLOT_W-1:0] slot,
    input logic              lost,
    input logic              pix_edge
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    // R5
    pd_off_chk: assert property (@(posedge clk)
        !pd_n |-> (!lane_oe_o && data_lane_o == 3'b000 && !clk_lane_o));

    // R5
    oe_on_chk: assert property (@(posedge clk) disable iff (!pd_n)
        $past(pd_n) |-> lane_oe_o);

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!pd_n)
        (bit_en && slot == LAST) |=> slot == '0);

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (!pd_n)
        (bit_en && slot != LAST) |=> slot == $past(slot) + 1'b1);

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (!pd_n)
        !bit_en |=> $stable(slot));

    // R3
    clk_pat_chk: assert property (@(posedge clk) disable iff (!pd_n)
        (bit_en && !lost) |=> clk_lane_o == CLK_PAT[slot]);

    // R6
    mute_chk: assert property (@(posedge clk) disable iff (!pd_n)
        (bit_en && lost) |=> (data_lane_o == 3'b000 && !clk_lane_o && lane_oe_o));

    // R7
    recover_chk: assert property (@(posedge clk) disable iff (!pd_n)
        $fell(lost) |-> $past(pix_edge));
endmodule

bind pixlink_serializer pxl_serializer_chk i_chk (
    .clk         (clk),
    .pd_n        (pd_n),
    .bit_en      (bit_en),
    .data_lane_o (data_lane_o),
    .clk_lane_o  (clk_lane_o),
    .lane_oe_o   (lane_oe_o),
    .slot        (slot_w),
    .lost        (lost_w),
    .pix_edge    (edge_w)
);

// File: tb/test_pixlink_serializer.sv
`timescale 1ns/1ps
module test_pixlink_serializer;
    logic        clk = 1'b0;
    logic        pd_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        pix_clk = 1'b0;
    logic        edge_rise = 1'b0;
    logic [5:0]  red = '0, grn = '0, blu = '0;
    logic        hsync = 1'b0, vsync = 1'b0, de = 1'b0;
    logic [2:0]  data_lane_o;
    logic        clk_lane_o;
    logic        lane_oe_o;

    int total = 0;
    int bad = 0;

    localparam logic [6:0] PAT = 7'b1100011;

    logic        pclk_run = 1'b0;
    int          ph = 13;
    int          fall_cnt = 0;
    logic [20:0] wa = '0, wb = '0;
    logic [20:0] cur_w;
    logic        adv = 1'b0, pd_pos = 1'b0;
    int          cur_slot = 6;
    logic [20:0] rx = '0, last_frame = '0;
    int          frames_done = 0;
    logic        chk_pat = 1'b0;
    int          pat_bad = 0;

    always #5 clk = ~clk;

    pixlink_serializer i_pixlink_serializer (
        .clk(clk), .pd_n(pd_n), .bit_en(bit_en), .pix_clk(pix_clk),
        .edge_rise(edge_rise), .red(red), .grn(grn), .blu(blu),
        .hsync(hsync), .vsync(vsync), .de(de),
        .data_lane_o(data_lane_o), .clk_lane_o(clk_lane_o), .lane_oe_o(lane_oe_o)
    );

    always @(posedge clk) begin
        adv    <= bit_en & pd_n;
        pd_pos <= pd_n;
    end

    // stimulus generator and lane monitor share one process at the falling edge
    always @(negedge clk) begin
        if (!pd_pos) begin
            cur_slot = 6;
        end else if (adv) begin
            cur_slot = (cur_slot == 6) ? 0 : cur_slot + 1;
            for (int k = 0; k < 3; k++) rx[k*7 + cur_slot] = data_lane_o[k];
            if (chk_pat && clk_lane_o != PAT[cur_slot]) pat_bad++;
            if (cur_slot == 6) begin
                last_frame = rx;
                frames_done++;
            end
        end
        bit_en = ~bit_en;
        if (pclk_run) begin
            ph = (ph == 13) ? 0 : ph + 1;
            if (ph == 7) fall_cnt++;
            pix_clk = (ph < 7);
        end
        cur_w = (ph >= 4 && ph <= 10) ? wb : wa;
        {de, vsync, hsync, blu, grn, red} = cur_w;
    end

    task automatic tick();
        @(posedge clk);
        #3;
    endtask

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_frames(input int n);
        int f0 = frames_done;
        while (frames_done < f0 + n) tick();
    endtask

    // returns OR of clock lane and OR of all lanes over a window
    task automatic window(input int n, output logic any_clk, output logic any_lane, output logic all_oe);
        any_clk = 1'b0; any_lane = 1'b0; all_oe = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick();
            any_clk  |= clk_lane_o;
            any_lane |= clk_lane_o | (|data_lane_o);
            all_oe   &= lane_oe_o;
        end
    endtask

    task automatic start_pclk();
        ph = 13;
        fall_cnt = 0;
        pclk_run = 1'b1;
    endtask

    task automatic t_reset();
        pd_n = 1'b0;
        repeat (5) tick();
        // R5: disabled and low while powered down
        check(lane_oe_o == 1'b0, "R5 oe in power-down", 32'(lane_oe_o), 0);
        check({data_lane_o, clk_lane_o} == 4'b0, "R5 lanes in power-down",
              32'({data_lane_o, clk_lane_o}), 0);
    endtask

    task automatic t_late_clock();
        logic ac, al, oe;
        @(negedge clk); #1 pd_n = 1'b1;
        repeat (60) tick();
        window(20, ac, al, oe);
        // R5 enable after release, R7 muted until clock arrives
        check(oe, "R5 oe after release", 32'(oe), 1);
        check(!al, "R7 muted with no pixel clock", 32'(al), 0);
        edge_rise = 1'b0;
        wa = 21'h0A5A5A;
        wb = 21'h13C3C3;
        start_pclk();
        while (!(fall_cnt == 3 && ph == 10)) tick();
        window(10, ac, al, oe);
        check(!al, "R7 still muted after third edge", 32'(al), 0);
        while (!(fall_cnt == 4 && ph == 11)) tick();
        window(12, ac, al, oe);
        check(ac, "R7 active after fourth edge", 32'(ac), 1);
    endtask

    task automatic t_words_falling();
        logic [20:0] pats [4] = '{21'h13C3C3, 21'h000001, 21'h100000, 21'h0F0F0F};
        edge_rise = 1'b0;
        chk_pat = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wb = pats[i];
            wa = ~pats[i];
            wait_frames(4);
            // R1 lane/slot mapping, R2 slot order, R4 falling-edge capture
            check(last_frame == wb, "R1 R2 R4 falling word", 32'(last_frame), 32'(wb));
        end
        chk_pat = 1'b0;
        // R3 clock lane slot pattern
        check(pat_bad == 0, "R3 clock lane pattern", 32'(pat_bad), 0);
    endtask

    task automatic t_rising();
        wa = 21'h1ABCDE;
        wb = 21'h054321;
        edge_rise = 1'b1;
        wait_frames(5);
        // R4 rising edge takes the value around the rising transition
        check(last_frame == wa, "R4 rising word", 32'(last_frame), 32'(wa));
        edge_rise = 1'b0;
        wait_frames(5);
        check(last_frame == wb, "R4 back to falling", 32'(last_frame), 32'(wb));
    endtask

    task automatic t_loss();
        logic ac, al, oe;
        while (ph != 8) tick();
        pclk_run = 1'b0;
        window(12, ac, al, oe);
        check(ac, "R6 active right after clock stops", 32'(ac), 1);
        repeat (30) tick();
        window(20, ac, al, oe);
        check(!al, "R6 lanes low on lost clock", 32'(al), 0);
        check(oe, "R6 oe kept on lost clock", 32'(oe), 1);
    endtask

    task automatic t_pd_mid();
        logic ac, al, oe;
        start_pclk();
        while (fall_cnt < 6) tick();
        window(12, ac, al, oe);
        check(ac, "R7 recovered after restart", 32'(ac), 1);
        @(negedge clk); #1 pd_n = 1'b0;
        #1;
        check(lane_oe_o == 1'b0 && {data_lane_o, clk_lane_o} == 4'b0, "R5 immediate power-down",
              32'({lane_oe_o, data_lane_o, clk_lane_o}), 0);
        repeat (4) tick();
        @(negedge clk); #1 pd_n = 1'b1;
        window(6, ac, al, oe);
        check(!al, "R7 muted after power-down release", 32'(al), 0);
        wb = 21'h1E1E1E;
        wa = 21'h01E1E1;
        wait_frames(8);
        check(last_frame == wb, "R1 R7 word after re-lock", 32'(last_frame), 32'(wb));
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_late_clock();
        t_words_falling();
        t_rising();
        t_loss();
        t_pd_mid();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule